// File: doc/BRIEF.md
# Double-Precision Subtraction Special-Operand Resolver

This combinational block looks at both operands of a double-precision subtraction (x minus y) and at the active rounding mode. It sorts each operand into one of six classes and decides whether the operand pair needs real arithmetic. If it does not, the block builds the final IEEE-754 result here and flags any invalid operation. Such pairs are NaNs, infinities and zeros.

When both operands are nonzero finite values (normal or denormal), the block raises a pass-through signal. The arithmetic datapath downstream then computes the difference. The class codes of both operands are also driven out, so that the datapath can see which operands are denormal. Flushing of denormals and pre-normalisation happen elsewhere.

NaN precedence is not symmetric. A signalling NaN in x always wins. Next comes a signalling NaN in y, which beats a quiet NaN in x. Then a quiet NaN in x, and last a quiet NaN in y. Quieting a signalling NaN only sets the most significant fraction bit (bit 51) and keeps the rest of the payload.

Top module: `fp64_sub_special`

## Requirements
- R1: Each operand is classed on its kind port as ZERO=0, NORM=1, DNORM=2, INF=3, QNAN=4, SNAN=5. An all-ones exponent with fraction bit 51 set is QNAN, and with bit 51 clear and a nonzero fraction it is SNAN.
- R2: When x is SNAN, the result is x with bit 51 set and the invalid flag is 1, whatever y is.
- R3: When y is SNAN and x is not, the result is y with bit 51 set and the invalid flag is 1.
- R4: When x is QNAN and y is not SNAN, the result is x unchanged and the invalid flag is 0.
- R5: When y is QNAN and x is not a NaN, the result is y unchanged.
- R6: Infinity minus infinity returns x when the signs differ. When the signs are equal it returns 64'h7FF7_FFFF_FFFF_FFFF with the invalid flag set.
- R7: A finite x minus an infinite y returns infinity whose sign is the inverse of y's sign.
- R8: An infinite x minus a finite y returns x.
- R9: Zero minus zero returns x when the signs differ. When the signs are equal it returns a zero that is negative only when the rounding mode is 2'b11 (toward minus infinity). The other codes are 00 nearest, 01 toward zero and 10 toward plus infinity, and all of them give +0.
- R10: A nonzero finite x minus a zero returns x.
- R11: A zero minus a nonzero finite y returns y with its sign bit inverted.
- R12: When both operands are nonzero finite, pass_arith is 1, special_ok is 0, flag_invalid is 0 and res_out is 0.
- R13: special_ok is always the inverse of pass_arith. flag_invalid is 1 only in the R2, R3 and equal-sign R6 cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | 64 | Minuend, IEEE-754 double |
| op_y | input | 64 | Subtrahend, IEEE-754 double |
| rnd_mode | input | 2 | Rounding mode: 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| res_out | output | 64 | Resolved result when special_ok is 1, otherwise 0 |
| special_ok | output | 1 | Result was resolved here |
| flag_invalid | output | 1 | Invalid-operation exception |
| pass_arith | output | 1 | Pair must go to the arithmetic datapath |
| x_kind | output | 3 | Class code of op_x |
| y_kind | output | 3 | Class code of op_y |

## Verification
The hardest cases to reach are the ones where both operands are NaNs of different kinds. Only there does the asymmetric precedence show: a quiet x loses to a signalling y, and a signalling x beats a signalling y. The vector table puts such pairs next to each other. The payloads and signs are chosen to differ, so a result taken from the wrong operand shows in the bits. The sign of the equal-zero result is exercised by sweeping all four rounding codes over +0 minus +0 and -0 minus -0.

// File: rtl/fp64_sub_pkg.sv
package fp64_sub_pkg;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    typedef enum logic [2:0] {
        KIND_ZERO  = 3'd0,
        KIND_NORM  = 3'd1,
        KIND_DNORM = 3'd2,
        KIND_INF   = 3'd3,
        KIND_QNAN  = 3'd4,
        KIND_SNAN  = 3'd5
    } kind_e;

    typedef enum logic [1:0] {
        RND_NEAREST = 2'b00,
        RND_ZERO    = 2'b01,
        RND_UP      = 2'b10,
        RND_DOWN    = 2'b11
    } rnd_e;
endpackage

// File: rtl/fp64_kind_decode.sv
module fp64_kind_decode
    import fp64_sub_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [EW+FW:0] word_in,
    output kind_e          kind_out
);
    localparam int QBIT = FW - 1;

    logic [EW-1:0] exp_f;
    logic [FW-1:0] frac_f;

    assign exp_f  = word_in[EW+FW-1:FW];
    assign frac_f = word_in[FW-1:0];

    always_comb begin
        if (&exp_f) begin
            if (frac_f == '0)
                kind_out = KIND_INF;
            else if (frac_f[QBIT])
                kind_out = KIND_QNAN;
            else
                kind_out = KIND_SNAN;
        end else if (exp_f == '0) begin
            kind_out = (frac_f == '0) ? KIND_ZERO : KIND_DNORM;
        end else begin
            kind_out = KIND_NORM;
        end
    end

    // R1: a zero class must carry all-zero magnitude bits
    always_comb begin
        if (kind_out == KIND_ZERO)
            a_r1_zero_bits: assert (word_in[EW+FW-1:0] == '0);
        if (kind_out == KIND_SNAN)
            a_r1_snan_payload: assert (word_in[FW-1:0] != '0 && !word_in[QBIT]);
    end
endmodule

// File: rtl/fp64_pair_resolve.sv
module fp64_pair_resolve
    import fp64_sub_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [EW+FW:0] xv,
    input  logic [EW+FW:0] yv,
    input  kind_e          xk,
    input  kind_e          yk,
    input  rnd_e           rm,
    output logic [EW+FW:0] res,
    output logic           done,
    output logic           inv
);
    localparam int WW   = 1 + EW + FW;
    localparam int SB   = WW - 1;
    localparam int QBIT = FW - 1;
    localparam logic [WW-1:0] QMASK   = {{(WW-1-QBIT){1'b0}}, 1'b1, {QBIT{1'b0}}};
    localparam logic [WW-1:0] INDEF   = {1'b0, {EW{1'b1}}, 1'b0, {(FW-1){1'b1}}};
    localparam logic [WW-2:0] INF_MAG = {{EW{1'b1}}, {FW{1'b0}}};

    logic x_nan, y_nan, x_fin, y_fin;

    assign x_nan = (xk == KIND_QNAN) || (xk == KIND_SNAN);
    assign y_nan = (yk == KIND_QNAN) || (yk == KIND_SNAN);
    assign x_fin = !x_nan && (xk != KIND_INF);
    assign y_fin = !y_nan && (yk != KIND_INF);

    always_comb begin
        res  = '0;
        done = 1'b1;
        inv  = 1'b0;
        if (xk == KIND_SNAN) begin
            res = xv | QMASK;
            inv = 1'b1;
        end else if (yk == KIND_SNAN) begin
            res = yv | QMASK;
            inv = 1'b1;
        end else if (xk == KIND_QNAN) begin
            res = xv;
        end else if (yk == KIND_QNAN) begin
            res = yv;
        end else begin
            unique case (xk)
                KIND_INF: begin
                    if (yk == KIND_INF && xv[SB] == yv[SB]) begin
                        res = INDEF;
                        inv = 1'b1;
                    end else begin
                        res = xv;
                    end
                end
                KIND_ZERO: begin
                    if (yk == KIND_INF)
                        res = {~yv[SB], INF_MAG};
                    else if (yk == KIND_ZERO)
                        res = (xv[SB] != yv[SB]) ? xv : {(rm == RND_DOWN), {(WW-1){1'b0}}};
                    else
                        res = {~yv[SB], yv[WW-2:0]};
                end
                default: begin
                    if (yk == KIND_INF)
                        res = {~yv[SB], INF_MAG};
                    else if (yk == KIND_ZERO)
                        res = xv;
                    else
                        done = 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        // R13: invalid only for signalling NaNs or like-signed infinities
        if (inv)
            a_r13_inv_cause: assert (xk == KIND_SNAN || yk == KIND_SNAN ||
                                     (xk == KIND_INF && yk == KIND_INF));
        // R12: two nonzero finite operands are never resolved here
        if (x_fin && y_fin && xk != KIND_ZERO && yk != KIND_ZERO)
            a_r12_pass: assert (!done && !inv && res == '0);
        // R2: an invalid outcome is always a NaN encoding
        if (inv)
            a_r2_nan_out: assert (&res[WW-2:FW] && res[FW-1:0] != '0);
        // R7: a finite minus an infinity yields an infinity
        if (x_fin && yk == KIND_INF)
            a_r7_inf_out: assert (res[WW-2:0] == INF_MAG && res[SB] != yv[SB]);
    end
endmodule

// File: rtl/fp64_sub_special.sv
module fp64_sub_special
    import fp64_sub_pkg::*;
(
    input  logic [63:0] op_x,
    input  logic [63:0] op_y,
    input  logic [1:0]  rnd_mode,
    output logic [63:0] res_out,
    output logic        special_ok,
    output logic        flag_invalid,
    output logic        pass_arith,
    output logic [2:0]  x_kind,
    output logic [2:0]  y_kind
);
    logic [WORD_W-1:0] ops [2];
    kind_e             kinds [2];
    logic              done_w;

    assign ops[0] = op_x;
    assign ops[1] = op_y;

    for (genvar g = 0; g < 2; g++) begin : g_dec
        fp64_kind_decode #(.EW(EXP_W), .FW(FRAC_W)) u_dec (
            .word_in (ops[g]),
            .kind_out(kinds[g])
        );
    end

    fp64_pair_resolve #(.EW(EXP_W), .FW(FRAC_W)) u_res (
        .xv  (op_x),
        .yv  (op_y),
        .xk  (kinds[0]),
        .yk  (kinds[1]),
        .rm  (rnd_e'(rnd_mode)),
        .res (res_out),
        .done(done_w),
        .inv (flag_invalid)
    );

    assign special_ok = done_w;
    assign pass_arith = ~done_w;
    assign x_kind     = kinds[0];
    assign y_kind     = kinds[1];

    // R13: resolved and pass-through are mutually exclusive
    always_comb begin
        a_r13_excl: assert (special_ok != pass_arith);
        if (pass_arith)
            a_r13_pass_clean: assert (!flag_invalid);
    end
endmodule

// File: tb/fp64_sub_special_test.sv
module fp64_sub_special_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [63:0] op_x, op_y, res_out;
    logic [1:0]  rnd_mode;
    logic        special_ok, flag_invalid, pass_arith;
    logic [2:0]  x_kind, y_kind;

    fp64_sub_special uut (
        .op_x(op_x), .op_y(op_y), .rnd_mode(rnd_mode),
        .res_out(res_out), .special_ok(special_ok), .flag_invalid(flag_invalid),
        .pass_arith(pass_arith), .x_kind(x_kind), .y_kind(y_kind)
    );

    localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
    localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] TWO  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] DN   = 64'h0000_0000_0000_0001;
    localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] QN   = 64'h7FF8_0000_0000_0123;
    localparam logic [63:0] QN2  = 64'hFFF8_0000_0000_0001;
    localparam logic [63:0] SN   = 64'h7FF0_0000_0000_0456;
    localparam logic [63:0] SNQ  = 64'h7FF8_0000_0000_0456;
    localparam logic [63:0] NSN  = 64'hFFF4_0000_0000_0000;
    localparam logic [63:0] NSNQ = 64'hFFFC_0000_0000_0000;
    localparam logic [63:0] IND  = 64'h7FF7_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic [63:0] x;
        logic [63:0] y;
        logic [1:0]  rm;
        logic [63:0] r;
        logic        v;
        logic        i;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VT [NV] = '{
        '{SN,   ONE,  2'b00, SNQ,  1'b1, 1'b1, 4'd2},   // R2
        '{SN,   NSN,  2'b00, SNQ,  1'b1, 1'b1, 4'd2},   // R2
        '{QN,   NSN,  2'b00, NSNQ, 1'b1, 1'b1, 4'd3},   // R3
        '{ONE,  SN,   2'b00, SNQ,  1'b1, 1'b1, 4'd3},   // R3
        '{QN,   PINF, 2'b00, QN,   1'b1, 1'b0, 4'd4},   // R4
        '{QN,   QN2,  2'b00, QN,   1'b1, 1'b0, 4'd4},   // R4
        '{PZ,   QN2,  2'b00, QN2,  1'b1, 1'b0, 4'd5},   // R5
        '{PINF, PINF, 2'b00, IND,  1'b1, 1'b1, 4'd6},   // R6
        '{PINF, NINF, 2'b00, PINF, 1'b1, 1'b0, 4'd6},   // R6
        '{ONE,  PINF, 2'b00, NINF, 1'b1, 1'b0, 4'd7},   // R7
        '{DN,   NINF, 2'b00, PINF, 1'b1, 1'b0, 4'd7},   // R7
        '{NINF, ONE,  2'b00, NINF, 1'b1, 1'b0, 4'd8},   // R8
        '{PZ,   NZ,   2'b11, PZ,   1'b1, 1'b0, 4'd9},   // R9
        '{NZ,   NZ,   2'b11, NZ,   1'b1, 1'b0, 4'd9},   // R9
        '{NZ,   NZ,   2'b00, PZ,   1'b1, 1'b0, 4'd9},   // R9
        '{ONE,  NZ,   2'b00, ONE,  1'b1, 1'b0, 4'd10},  // R10
        '{PZ,   TWO,  2'b00, 64'hC000_0000_0000_0000, 1'b1, 1'b0, 4'd11}, // R11
        '{NZ,   DN,   2'b00, 64'h8000_0000_0000_0001, 1'b1, 1'b0, 4'd11}, // R11
        '{ONE,  TWO,  2'b00, PZ,   1'b0, 1'b0, 4'd12},  // R12
        '{DN,   DN,   2'b00, PZ,   1'b0, 1'b0, 4'd12}   // R12
    };

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [63:0] x, input logic [63:0] y, input logic [1:0] rm);
        @(posedge clk);
        op_x = x; op_y = y; rnd_mode = rm;
        @(negedge clk);
    endtask

    initial begin
        op_x = PZ; op_y = PZ; rnd_mode = 2'b00;
        @(negedge clk);
        // idle state: +0 - +0 resolves to +0 (R9), R13 exclusivity
        check("R9", res_out, PZ);
        check("R13", {63'd0, special_ok ^ pass_arith}, 64'd1);

        for (int k = 0; k < NV; k++) begin
            string tag;
            tag = $sformatf("R%0d", VT[k].req);
            apply(VT[k].x, VT[k].y, VT[k].rm);
            check(tag, res_out, VT[k].r);
            check(tag, {62'd0, special_ok, flag_invalid}, {62'd0, VT[k].v, VT[k].i});
            check("R13", {63'd0, pass_arith}, {63'd0, ~VT[k].v});
        end

        // R1 class codes
        apply(PZ, ONE, 2'b00);  check("R1", {61'd0, x_kind}, 64'd0); check("R1", {61'd0, y_kind}, 64'd1);
        apply(DN, PINF, 2'b00); check("R1", {61'd0, x_kind}, 64'd2); check("R1", {61'd0, y_kind}, 64'd3);
        apply(QN, SN, 2'b00);   check("R1", {61'd0, x_kind}, 64'd4); check("R1", {61'd0, y_kind}, 64'd5);
        apply(NSN, QN2, 2'b00); check("R1", {61'd0, x_kind}, 64'd5); check("R1", {61'd0, y_kind}, 64'd4);

        // R9 rounding-mode sweep on equal-signed zeros
        for (int m = 0; m < 4; m++) begin
            apply(PZ, PZ, m[1:0]);
            check("R9", res_out, (m == 3) ? NZ : PZ);
            apply(NZ, NZ, m[1:0]);
            check("R9", res_out, (m == 3) ? NZ : PZ);
        end

        // R6 negative infinities of equal sign
        apply(NINF, NINF, 2'b11);
        check("R6", res_out, IND);
        check("R6", {63'd0, flag_invalid}, 64'd1);

        // R12 large and tiny normals pass through
        apply(64'h7FEF_FFFF_FFFF_FFFF, 64'h0010_0000_0000_0000, 2'b10);
        check("R12", {63'd0, pass_arith}, 64'd1);
        check("R12", res_out, PZ);

        finished = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 10000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule